// File: doc/BRIEF.md
# MII PHY Management Register Model

This block models the management register set of a 10/100 Ethernet PHY as a MAC sees it. The MAC side first writes a target word that names a PHY address and a register number. A strobed data write then updates the selected PHY register. A read port continuously returns the contents of the selected register. Serial management bit timing, real auto-negotiation and any datapath effects are outside this model.

The model holds a control register, a status register, an advertisement register, a link-partner ability register and two fixed identifier registers. A link input drives the link-related status bits and the partner ability value. Setting the reset bit of the control register reloads the writable registers and reapplies the current link state. An access aimed at any other PHY address reads all ones and changes nothing.

Top module: `mii_mgmt_regs`

## Requirements
- R1: After reset the target word is 0 (PHY address 0, register 0), the control register (number 0) reads 0x3100 (speed 100 at bit 13, auto-negotiation enable at bit 12, full duplex at bit 8), and the advertisement register (number 4) reads 0x01E1.
- R2: The status register (number 1) always holds ability bits 0x7848 (bits 14, 13, 12, 11, 6 and 3); with the link up it also sets link status (bit 2) and auto-negotiation complete (bit 5), reading 0x786C, and with the link down it reads 0x7848.
- R3: The partner ability register (number 5) reads 0x01E0 (bits 8, 6, 5 and 7) while the link is up and exactly 0x0080 (bit 7 only) while it is down.
- R4: A change on `link_up_i` appears on the status and partner ability values one rising clock edge later, not in the same cycle.
- R5: With the target's PHY address field not equal to the parameter `PHY_ADDR` (default 0), reads return 0xFFFF and data writes change no register.
- R6: A data write to register 0 with bit 15 clear stores the written value; a data write to register 4 stores the written value; bit 15 of register 0 always reads 0.
- R7: A data write to register 0 with bit 15 set returns registers 0 and 4 to 0x3100 and 0x01E1, while status and partner ability keep following the current link input.
- R8: Data writes to registers 1, 2, 3 and 5 are discarded and those registers keep their values.
- R9: The target word places the PHY address in bits 15:8 and the register number in bits 7:0; bits 31:16 are ignored. A target write takes effect at the next rising edge.
- R10: Register numbers other than 0 to 5 read 0 at the matching PHY address, and writes to them have no effect.
- R11: Identifier registers 2 and 3 read the parameters `ID_HI` (default 0x0243) and `ID_LO` (default 0x0C54).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up_i | input | 1 | Link state from the line side, 1 = up |
| tgt_wr_i | input | 1 | Load strobe for the target word |
| tgt_data_i | input | 32 | Target word: PHY address and register number |
| wr_i | input | 1 | Data write strobe to the selected register |
| wr_data_i | input | 16 | Data for a management write |
| rd_data_o | output | 16 | Contents of the selected register |

## Verification
The assertions assume `rst_n` is held low across at least one rising edge before any check, so the sampled link flop holds a known value, and that `link_up_i` is a clean synchronous level. They also assume a data write and a target write in the same cycle act on the old target. The stimulus changes every input only at the falling edge, always loads the target in a cycle of its own before a data write, and keeps reset low for four edges with the link held down.

// File: rtl/mii_mgmt_regs.sv
module mii_mgmt_regs #(
  parameter logic [7:0]  PHY_ADDR = 8'd0,
  parameter logic [15:0] ID_HI    = 16'h0243,
  parameter logic [15:0] ID_LO    = 16'h0C54
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up_i,
  input  logic        tgt_wr_i,
  input  logic [31:0] tgt_data_i,
  input  logic        wr_i,
  input  logic [15:0] wr_data_i,
  output logic [15:0] rd_data_o
);
  localparam logic [7:0]  REG_CTL   = 8'd0;
  localparam logic [7:0]  REG_STAT  = 8'd1;
  localparam logic [7:0]  REG_ID_HI = 8'd2;
  localparam logic [7:0]  REG_ID_LO = 8'd3;
  localparam logic [7:0]  REG_ADV   = 8'd4;
  localparam logic [7:0]  REG_LP    = 8'd5;
  localparam logic [15:0] CTL_INIT  = 16'h3100;
  localparam logic [15:0] ADV_INIT  = 16'h01E1;
  localparam logic [15:0] STAT_CAPS = 16'h7848;
  localparam logic [15:0] STAT_LINK = 16'h0024;
  localparam logic [15:0] LP_UP     = 16'h01E0;
  localparam logic [15:0] LP_DOWN   = 16'h0080;
  localparam int          SOFT_RST  = 15;

  logic [15:0] tgt_q;
  logic [15:0] ctl_q;
  logic [15:0] adv_q;
  logic        link_q;
  logic        unused_tgt_hi;

  wire [7:0]  tgt_phy = tgt_q[15:8];
  wire [7:0]  tgt_reg = tgt_q[7:0];
  wire        hit     = (tgt_phy == PHY_ADDR);
  wire [15:0] stat_v  = link_q ? (STAT_CAPS | STAT_LINK) : STAT_CAPS;
  wire [15:0] lp_v    = link_q ? LP_UP : LP_DOWN;

  assign unused_tgt_hi = ^tgt_data_i[31:16];

  always_ff @(posedge clk)
    link_q <= link_up_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q <= '0;
      ctl_q <= CTL_INIT;
      adv_q <= ADV_INIT;
    end else begin
      if (tgt_wr_i)
        tgt_q <= tgt_data_i[15:0];
      if (wr_i && hit) begin
        case (tgt_reg)
          REG_CTL:
            if (wr_data_i[SOFT_RST]) begin
              ctl_q <= CTL_INIT;
              adv_q <= ADV_INIT;
            end else begin
              ctl_q <= wr_data_i;
            end
          REG_ADV: adv_q <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    if (!hit) begin
      rd_data_o = 16'hFFFF;
    end else begin
      case (tgt_reg)
        REG_CTL:   rd_data_o = ctl_q;
        REG_STAT:  rd_data_o = stat_v;
        REG_ID_HI: rd_data_o = ID_HI;
        REG_ID_LO: rd_data_o = ID_LO;
        REG_ADV:   rd_data_o = adv_q;
        REG_LP:    rd_data_o = lp_v;
        default:   rd_data_o = 16'h0000;
      endcase
    end
  end
endmodule

// File: rtl/mii_mgmt_regs_chk.sv
module mii_mgmt_regs_chk #(
  parameter logic [7:0] PHY_ADDR = 8'd0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        link_up_i,
  input logic        wr_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic [15:0] tgt_q,
  input logic [15:0] ctl_q,
  input logic [15:0] adv_q
);
  wire sel_ok = (tgt_q[15:8] == PHY_ADDR);
  wire [7:0] sel_reg = tgt_q[7:0];

  p_foreign_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |-> rd_data_o == 16'hFFFF);

  p_foreign_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !sel_ok) |=> ($stable(ctl_q) && $stable(adv_q)));

  p_link_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && sel_reg == 8'd1) |-> (rd_data_o[2] == $past(link_up_i) && rd_data_o[5] == $past(link_up_i)));

  p_status_caps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && sel_reg == 8'd1) |-> ((rd_data_o & ~16'h0024) == 16'h7848));

  p_partner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && sel_reg == 8'd5) |-> (rd_data_o == ($past(link_up_i) ? 16'h01E0 : 16'h0080)));

  p_soft_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_ok && sel_reg == 8'd0 && wr_data_i[15]) |=> (ctl_q == 16'h3100 && adv_q == 16'h01E1));

  p_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_reg != 8'd0 && sel_reg != 8'd4) |=> ($stable(ctl_q) && $stable(adv_q)));

  p_rst_bit_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && sel_reg == 8'd0) |-> !rd_data_o[15]);
endmodule

bind mii_mgmt_regs mii_mgmt_regs_chk #(.PHY_ADDR(PHY_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .link_up_i (link_up_i),
  .wr_i      (wr_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .tgt_q     (tgt_q),
  .ctl_q     (ctl_q),
  .adv_q     (adv_q)
);

// File: tb/test_mii_mgmt_regs.sv
`timescale 1ns/1ps
module test_mii_mgmt_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up_i = 1'b0;
  logic        tgt_wr_i = 1'b0;
  logic [31:0] tgt_data_i = '0;
  logic        wr_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  mii_mgmt_regs i_mii_mgmt_regs (
    .clk(clk), .rst_n(rst_n), .link_up_i(link_up_i),
    .tgt_wr_i(tgt_wr_i), .tgt_data_i(tgt_data_i),
    .wr_i(wr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o)
  );

  // {req[68:65], target[64:33], write[32], wdata[31:16], expected[15:0]}, link up
  localparam int NV = 15;
  localparam logic [68:0] VEC [NV] = '{
    {4'd6,  32'h0000_0004, 1'b1, 16'h0061, 16'h0061},  // R6 advertisement store
    {4'd6,  32'h0000_0000, 1'b1, 16'h1100, 16'h1100},  // R6 control store
    {4'd8,  32'h0000_0001, 1'b1, 16'h0000, 16'h786C},  // R8 R2 status read-only
    {4'd11, 32'h0000_0002, 1'b1, 16'hAAAA, 16'h0243},  // R11 R8 id high
    {4'd11, 32'h0000_0003, 1'b1, 16'h5555, 16'h0C54},  // R11 R8 id low
    {4'd8,  32'h0000_0005, 1'b1, 16'h0000, 16'h01E0},  // R8 R3 partner read-only
    {4'd5,  32'h0000_0100, 1'b1, 16'h0000, 16'hFFFF},  // R5 foreign address
    {4'd5,  32'h0000_0000, 1'b0, 16'h0000, 16'h1100},  // R5 foreign write ignored
    {4'd10, 32'h0000_0009, 1'b1, 16'h1234, 16'h0000},  // R10 unimplemented
    {4'd10, 32'h0000_001F, 1'b0, 16'h0000, 16'h0000},  // R10
    {4'd6,  32'h0000_0000, 1'b1, 16'h0300, 16'h0300},  // R6 second pattern
    {4'd7,  32'h0000_0000, 1'b1, 16'h8000, 16'h3100},  // R7 soft reset
    {4'd7,  32'h0000_0004, 1'b0, 16'h0000, 16'h01E1},  // R7 advertisement reloaded
    {4'd7,  32'h0000_0001, 1'b0, 16'h0000, 16'h786C},  // R7 link reapplied
    {4'd9,  32'hABCD_0104, 1'b0, 16'h0000, 16'hFFFF}   // R9 field positions
  };

  task automatic check(input string tag, input logic [15:0] exp);
    tests++;
    if (rd_data_o !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h", tag, rd_data_o, exp);
    end
  endtask

  task automatic set_tgt(input logic [31:0] t);
    @(negedge clk); tgt_wr_i = 1'b1; tgt_data_i = t;
    @(negedge clk); tgt_wr_i = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] d);
    @(negedge clk); wr_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 control after reset, target 0", 16'h3100);
    set_tgt(32'h4);
    check("R1 advertisement after reset", 16'h01E1);
    set_tgt(32'h1);
    check("R2 status link down", 16'h7848);
    set_tgt(32'h5);
    check("R3 partner link down", 16'h0080);
    set_tgt(32'h1);
    @(negedge clk); link_up_i = 1'b1;
    check("R4 no change before edge", 16'h7848);
    @(negedge clk);
    check("R4 status after one edge", 16'h786C);
    set_tgt(32'h5);
    check("R3 partner link up", 16'h01E0);

    for (int i = 0; i < NV; i++) begin
      set_tgt(VEC[i][64:33]);
      if (VEC[i][32]) do_write(VEC[i][31:16]);
      check($sformatf("R%0d vector %0d", VEC[i][68:65], i), VEC[i][15:0]);
    end

    set_tgt(32'h1);
    @(negedge clk); link_up_i = 1'b0;
    @(negedge clk);
    check("R2 status after link drop", 16'h7848);
    set_tgt(32'h0); do_write(16'h0000);
    set_tgt(32'h4); do_write(16'h0000);
    check("R6 advertisement cleared", 16'h0000);
    set_tgt(32'h0); do_write(16'h8000);
    check("R7 control reloaded, link down", 16'h3100);
    set_tgt(32'h4);
    check("R7 advertisement reloaded, link down", 16'h01E1);
    set_tgt(32'h5);
    check("R7 partner keeps link-down value", 16'h0080);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule